// File: doc/BRIEF.md
# Multicycle Processor Core with Unified Memory Port

This block is a small processor core that runs each instruction as a sequence of short cycles rather than in one long cycle. A single memory port carries instruction fetches and data loads and stores, in different cycles. A single ALU does all of the core's arithmetic: the PC increment, the branch-target sum, address generation and the instruction's own operation. Values that must survive from one cycle to the next are parked in holding registers that software cannot see. These are the instruction register, two operand latches, an ALU result latch and a memory data latch.

The core drives a word-addressed memory. Writes take effect at the clock edge that ends the write cycle. Read data must come back combinationally in the same cycle as the address. The port has no valid/ready handshake and no back-pressure: the memory must answer every request in the cycle it is made, and the core never stalls. A status pin marks the fetch cycle, so that the surrounding system can count cycles per instruction. The instruction classes are register-register ALU operations, ALU operations with an immediate, word load, word store and branch-if-equal. Branches take 3 cycles, loads take 5, and every other defined instruction takes 4.

Top module: `mcore_top`

## Requirements
- R1: One memory port serves every access. A fetch reads at the PC. A load or store uses the address the ALU produced in the execute cycle. Read enable and write enable are never high together. The word address on the port is byte address bits [31:2].
- R2: After reset the PC and all 32 general registers are zero, and the first cycle after reset is a fetch from word 0.
- R3: Instruction fields are taken from fixed positions: opcode [31:26], source register [25:21], second register [20:16], destination register [15:11], function [5:0], immediate [15:0] sign-extended. The instruction register holds the word unchanged from the end of its fetch until the next fetch.
- R4: Opcode 0x00 uses the function field. 0x20 is add, 0x22 is subtract, 0x24 is AND, 0x25 is OR and 0x2A is signed set-less-than. The result is written to the destination register, and the instruction takes 4 cycles.
- R5: Opcodes 0x08 (add), 0x0C (AND), 0x0D (OR) and 0x0A (signed set-less-than) combine the source register with the sign-extended immediate. The result is written to the second register field, and the instruction takes 4 cycles.
- R6: Opcode 0x23 loads the word at source register plus immediate into the second register field, and takes 5 cycles.
- R7: Opcode 0x2B stores the second register field's value at source register plus immediate, and takes 4 cycles.
- R8: Opcode 0x04 compares the two register fields. When they are equal, the next fetch is at PC+4+immediate*4; otherwise it is at PC+4. The instruction takes 3 cycles whether or not the branch is taken.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode changes no register and no memory word, takes 2 cycles, and is followed by a fetch of the next word.
- R11: The fetch status pin is high exactly in fetch cycles. After a non-branch instruction, the next fetch address is one word above the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | MEM_AW (30) | Word address, byte address bits [31:2] |
| mem_rd_en | output | 1 | Read request; data expected on mem_rdata in the same cycle |
| mem_wr_en | output | 1 | Write request, committed at the next rising edge |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for the current address |
| instr_fetch | output | 1 | High in the first cycle of every instruction |

## Verification
Some properties are checked by the assertions on every cycle: the memory port never reads and writes at once; a fetch always reads at the PC and moves it on by 4; the instruction register is frozen outside fetch; register 0 reads zero; a store and a load each end the instruction at the expected cycle; and no instruction is shorter than two cycles. Other behaviour can only be shown by the bench's program. This covers the arithmetic of every ALU operation over a grid of signed corner operands, the sign extension of immediates, the choice between taken and not-taken branch targets including a backward loop, that an undefined opcode has no effect, and the exact cycle count of each executed instruction by class.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam int XLEN   = 32;
  localparam int REG_N  = 32;
  localparam int REG_AW = $clog2(REG_N);
  localparam int IMM_W  = 16;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMRD, ST_MEMWR, ST_REGWB, ST_LOADWB
  } state_e;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMSH
  } srcb_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_RTYPE, CLS_IMM, CLS_LOAD, CLS_STORE, CLS_BRANCH
  } cls_e;

  typedef struct packed {
    logic    ir_we;
    logic    pc_we;
    logic    pc_cond;
    logic    pc_from_aluout;
    logic    addr_from_aluout;
    logic    mem_rd;
    logic    mem_wr;
    logic    srca_reg;
    srcb_e   srcb;
    alu_op_e alu_op;
    logic    ab_we;
    logic    aluout_we;
    logic    mdr_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
  } ctrl_t;

endpackage

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y,
  output logic              zero
);

  logic less;

  always_comb begin
    less = ($signed(a) < $signed(b));
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, less};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra1,
  input  logic [AW-1:0]     ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd
);

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    if (g == 0) begin : g_zero
      assign cells[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (we && (wa == AW'(g))) begin
          q <= wd;
        end
      end
      assign cells[g] = q;
    end
  end

  assign rd1 = cells[ra1];
  assign rd2 = cells[ra2];

endmodule

// File: rtl/mcore_ctrl.sv
module mcore_ctrl
  import mcore_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output state_e     state
);

  state_e  st_q;
  state_e  st_d;
  cls_e    cls;
  alu_op_e exec_op;

  function automatic cls_e classify(input logic [5:0] opc);
    cls_e c;
    unique case (opc)
      OPC_RTYPE:                           c = CLS_RTYPE;
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI: c = CLS_IMM;
      OPC_LW:                              c = CLS_LOAD;
      OPC_SW:                              c = CLS_STORE;
      OPC_BEQ:                             c = CLS_BRANCH;
      default:                             c = CLS_NONE;
    endcase
    return c;
  endfunction

  always_comb cls = classify(opcode);

  // operation used in the execute cycle
  always_comb begin
    exec_op = ALU_ADD;
    unique case (cls)
      CLS_RTYPE: begin
        unique case (funct)
          FN_SUB:  exec_op = ALU_SUB;
          FN_AND:  exec_op = ALU_AND;
          FN_OR:   exec_op = ALU_OR;
          FN_SLT:  exec_op = ALU_SLT;
          default: exec_op = ALU_ADD;
        endcase
      end
      CLS_IMM: begin
        unique case (opcode)
          OPC_SLTI: exec_op = ALU_SLT;
          OPC_ANDI: exec_op = ALU_AND;
          OPC_ORI:  exec_op = ALU_OR;
          default:  exec_op = ALU_ADD;
        endcase
      end
      CLS_BRANCH: exec_op = ALU_SUB;
      default:    exec_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl  = '0;
    st_d = st_q;
    unique case (st_q)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.srcb   = SRCB_FOUR;
        ctl.alu_op = ALU_ADD;
        ctl.pc_we  = 1'b1;
        st_d       = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_we     = 1'b1;
        ctl.srcb      = SRCB_IMMSH;
        ctl.alu_op    = ALU_ADD;
        ctl.aluout_we = 1'b1;
        st_d          = (cls == CLS_NONE) ? ST_FETCH : ST_EXEC;
      end
      ST_EXEC: begin
        ctl.srca_reg = 1'b1;
        ctl.alu_op   = exec_op;
        ctl.srcb     = ((cls == CLS_RTYPE) || (cls == CLS_BRANCH)) ? SRCB_REG : SRCB_IMM;
        if (cls == CLS_BRANCH) begin
          ctl.pc_cond        = 1'b1;
          ctl.pc_from_aluout = 1'b1;
          st_d               = ST_FETCH;
        end else begin
          ctl.aluout_we = 1'b1;
          unique case (cls)
            CLS_LOAD:  st_d = ST_MEMRD;
            CLS_STORE: st_d = ST_MEMWR;
            default:   st_d = ST_REGWB;
          endcase
        end
      end
      ST_MEMRD: begin
        ctl.addr_from_aluout = 1'b1;
        ctl.mem_rd           = 1'b1;
        ctl.mdr_we           = 1'b1;
        st_d                 = ST_LOADWB;
      end
      ST_MEMWR: begin
        ctl.addr_from_aluout = 1'b1;
        ctl.mem_wr           = 1'b1;
        st_d                 = ST_FETCH;
      end
      ST_REGWB: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = (cls == CLS_RTYPE);
        st_d          = ST_FETCH;
      end
      ST_LOADWB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
        st_d            = ST_FETCH;
      end
      default: st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int MEM_AW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              instr_fetch
);

  localparam int BYTE_SH = 2;
  localparam int EXT_W   = XLEN - IMM_W;

  // holding registers
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;

  ctrl_t  ctl;
  state_e state;

  logic [XLEN-1:0]   alu_a, alu_b, alu_y;
  logic              alu_zero;
  logic [XLEN-1:0]   imm_ext, imm_sh;
  logic [XLEN-1:0]   rf_rd1, rf_rd2, rf_wd;
  logic [REG_AW-1:0] rf_wa;
  logic [XLEN-1:0]   byte_addr;
  logic [XLEN-1:0]   pc_d;
  logic              pc_load;

  logic [5:0]        f_opcode, f_funct;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;

  assign f_opcode = ir_q[31:26];
  assign f_rs     = ir_q[25:21];
  assign f_rt     = ir_q[20:16];
  assign f_rd     = ir_q[15:11];
  assign f_funct  = ir_q[5:0];
  assign imm_ext  = {{EXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh   = {imm_ext[XLEN-3:0], 2'b00};

  mcore_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (f_opcode),
    .funct  (f_funct),
    .ctl    (ctl),
    .state  (state)
  );

  mcore_regfile #(.DATA_W(XLEN), .DEPTH(REG_N)) rf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl.rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // ALU source selection
  assign alu_a = ctl.srca_reg ? a_q : pc_q;

  always_comb begin
    unique case (ctl.srcb)
      SRCB_REG:   alu_b = b_q;
      SRCB_FOUR:  alu_b = XLEN'(4);
      SRCB_IMM:   alu_b = imm_ext;
      SRCB_IMMSH: alu_b = imm_sh;
      default:    alu_b = b_q;
    endcase
  end

  mcore_alu #(.DATA_W(XLEN)) alu_i (
    .a    (alu_a),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // shared memory port
  assign byte_addr   = ctl.addr_from_aluout ? aluout_q : pc_q;
  assign mem_addr    = byte_addr[MEM_AW+BYTE_SH-1:BYTE_SH];
  assign mem_rd_en   = ctl.mem_rd;
  assign mem_wr_en   = ctl.mem_wr;
  assign mem_wdata   = b_q;
  assign instr_fetch = (state == ST_FETCH);

  // register file write selection
  assign rf_wa = ctl.rf_dst_rd ? f_rd : f_rt;
  assign rf_wd = ctl.rf_from_mdr ? mdr_q : aluout_q;

  // PC update
  assign pc_d    = ctl.pc_from_aluout ? aluout_q : alu_y;
  assign pc_load = ctl.pc_we | (ctl.pc_cond & alu_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_load)       pc_q     <= pc_d;
      if (ctl.ir_we)     ir_q     <= mem_rdata;
      if (ctl.ab_we)     a_q      <= rf_rd1;
      if (ctl.ab_we)     b_q      <= rf_rd2;
      if (ctl.aluout_we) aluout_q <= alu_y;
      if (ctl.mdr_we)    mdr_q    <= mem_rdata;
    end
  end

endmodule

// File: rtl/mcore_chk.sv
module mcore_chk #(
  parameter int MEM_AW = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              instr_fetch,
  input logic [31:0]       pc_q,
  input logic [31:0]       ir_q,
  input logic [31:0]       rf_rd1
);

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R1

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    instr_fetch |-> (mem_rd_en && (mem_addr == pc_q[MEM_AW+1:2]))); // R1

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_fetch |=> (pc_q == $past(pc_q) + 32'd4)); // R11

  AST_IR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_fetch |=> $stable(ir_q)); // R3

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |-> (rf_rd1 == 32'd0)); // R9

  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    instr_fetch |=> !instr_fetch); // R10

  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> instr_fetch); // R7

  AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !instr_fetch) |=> (!instr_fetch ##1 instr_fetch)); // R6

endmodule

bind mcore_top mcore_chk #(.MEM_AW(MEM_AW)) chk_i (.*);

// File: tb/mcore_top_tb_top.sv
module mcore_top_tb_top;
  import mcore_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 2048;
  localparam int DATA_BASE  = 1024;
  localparam int RES1       = DATA_BASE + 100;
  localparam int RES2       = DATA_BASE + 300;
  localparam int MISC       = DATA_BASE + 450;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] mem_addr;
  logic        mem_rd_en, mem_wr_en, instr_fetch;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [MEM_WORDS];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_cyc = 0;
  int prev_addr = 0;
  int end_word = 0;
  int pw = 0;
  int overlap = 0;
  int badwrite = 0;
  int measured = 0;
  bit have_prev = 0;
  bit done = 0;
  bit timeout = 0;

  logic [31:0] vals [6];
  logic [15:0] imms [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcore_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr    (mem_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .instr_fetch (instr_fetch)
  );

  assign mem_rdata = mem[mem_addr[10:0]];

  always @(posedge clk) begin
    if (rst_n && mem_wr_en) mem[mem_addr[10:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {OPC_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic put(input logic [31:0] w);
    mem[pw] = w;
    pw++;
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_ref(input int t, input logic [31:0] a, input logic [31:0] b);
    case (t)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic int exp_cycles(input logic [31:0] w);
    case (w[31:26])
      OPC_BEQ: return 3;
      OPC_LW:  return 5;
      OPC_RTYPE, OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_SW: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic string cls_tag(input logic [31:0] w);
    case (w[31:26])
      OPC_BEQ: return "R8 cycles";
      OPC_LW:  return "R6 cycles";
      OPC_SW:  return "R7 cycles";
      OPC_RTYPE: return "R4 cycles";
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI: return "R5 cycles";
      default: return "R10 cycles";
    endcase
  endfunction

  // per-instruction cycle monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done && !timeout) begin
      cyc++;
      if (cyc >= WATCHDOG) timeout = 1;
      if (mem_rd_en && mem_wr_en) overlap++;
      if (mem_wr_en && (int'(mem_addr) < end_word + 1)) badwrite++;
      if (instr_fetch) begin
        if (have_prev) begin
          measured++;
          chk((cyc - prev_cyc) == exp_cycles(mem[prev_addr]), cls_tag(mem[prev_addr]),
              32'(cyc - prev_cyc), 32'(exp_cycles(mem[prev_addr])));
          if (mem[prev_addr][31:26] != OPC_BEQ)
            chk(int'(mem_addr) == prev_addr + 1, "R11 next fetch",
                32'(mem_addr), 32'(prev_addr + 1));
        end
        have_prev = 1;
        prev_cyc  = cyc;
        prev_addr = int'(mem_addr);
        if (int'(mem_addr) == end_word) done = 1;
      end
    end
  end

  initial begin
    int loop_top;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'hFFFF;
    imms[3] = 16'h7FFF; imms[4] = 16'h8000; imms[5] = 16'h1234;

    for (int k = 0; k < MEM_WORDS; k++) mem[k] = 32'hDEAD_BEEF;
    for (int k = 0; k < 6; k++) mem[DATA_BASE + k] = vals[k];

    // base pointer r10 = byte address of the data area
    put(enc_i(OPC_ADDI, 0, 10, 16'(DATA_BASE * 4)));
    // register-register sweep over operand pairs
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        int k;
        k = i * 6 + j;
        put(enc_i(OPC_LW, 10, 1, 16'(4 * i)));
        put(enc_i(OPC_LW, 10, 2, 16'(4 * j)));
        put(enc_r(1, 2, 3, FN_ADD));
        put(enc_r(1, 2, 4, FN_SUB));
        put(enc_r(1, 2, 5, FN_AND));
        put(enc_r(1, 2, 6, FN_OR));
        put(enc_r(1, 2, 7, FN_SLT));
        for (int t = 0; t < 5; t++)
          put(enc_i(OPC_SW, 10, 3 + t, 16'((RES1 - DATA_BASE + k * 5 + t) * 4)));
      end
    end
    // immediate sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        int n;
        n = i * 6 + j;
        put(enc_i(OPC_LW, 10, 1, 16'(4 * i)));
        put(enc_i(OPC_ADDI, 1, 3, imms[j]));
        put(enc_i(OPC_ANDI, 1, 4, imms[j]));
        put(enc_i(OPC_ORI, 1, 5, imms[j]));
        put(enc_i(OPC_SLTI, 1, 6, imms[j]));
        for (int t = 0; t < 4; t++)
          put(enc_i(OPC_SW, 10, 3 + t, 16'((RES2 - DATA_BASE + n * 4 + t) * 4)));
      end
    end
    // register 0 writes are discarded
    put(enc_i(OPC_ADDI, 0, 0, 16'd5));
    put(enc_i(OPC_SW, 10, 0, 16'((MISC - DATA_BASE) * 4)));
    put(enc_r(10, 10, 0, FN_ADD));
    put(enc_i(OPC_SW, 10, 0, 16'((MISC - DATA_BASE + 1) * 4)));
    // taken and not-taken forward branches
    put(enc_i(OPC_ADDI, 0, 3, 16'd0));
    put(enc_i(OPC_ADDI, 0, 1, 16'd7));
    put(enc_i(OPC_ADDI, 0, 2, 16'd7));
    put(enc_i(OPC_BEQ, 1, 2, 16'd1));
    put(enc_i(OPC_ADDI, 0, 3, 16'd99));
    put(enc_i(OPC_ADDI, 0, 4, 16'd11));
    put(enc_i(OPC_BEQ, 1, 0, 16'd1));
    put(enc_i(OPC_ADDI, 0, 5, 16'd22));
    put(enc_i(OPC_SW, 10, 3, 16'((MISC - DATA_BASE + 2) * 4)));
    put(enc_i(OPC_SW, 10, 4, 16'((MISC - DATA_BASE + 3) * 4)));
    put(enc_i(OPC_SW, 10, 5, 16'((MISC - DATA_BASE + 4) * 4)));
    // backward loop: three passes adding 5
    put(enc_i(OPC_ADDI, 0, 6, 16'd3));
    put(enc_i(OPC_ADDI, 0, 7, 16'd0));
    loop_top = pw;
    put(enc_i(OPC_ADDI, 7, 7, 16'd5));
    put(enc_i(OPC_ADDI, 6, 6, 16'hFFFF));
    put(enc_i(OPC_BEQ, 6, 0, 16'd1));
    put(enc_i(OPC_BEQ, 0, 0, 16'(loop_top - pw - 1)));
    put(enc_i(OPC_SW, 10, 7, 16'((MISC - DATA_BASE + 5) * 4)));
    // undefined opcode, then a never-written register
    put(32'hFFFF_FFFF);
    put(enc_i(OPC_SW, 10, 31, 16'((MISC - DATA_BASE + 6) * 4)));
    end_word = pw;
    put(enc_i(OPC_BEQ, 0, 0, 16'hFFFF));

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(instr_fetch == 1'b1, "R2 fetch after reset", 32'(instr_fetch), 32'd1);
    chk(mem_addr == 30'd0, "R2 first fetch address", 32'(mem_addr), 32'd0);
    chk(mem_rd_en && !mem_wr_en, "R1 fetch is a read", {mem_rd_en, mem_wr_en}, 32'd2);

    wait (done || timeout);
    @(negedge clk);

    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
    end else begin
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int t = 0; t < 5; t++) begin
            logic [31:0] e;
            e = alu_ref(t, vals[i], vals[j]);
            chk(mem[RES1 + (i * 6 + j) * 5 + t] == e, "R4 R6 R3 reg-reg result",
                mem[RES1 + (i * 6 + j) * 5 + t], e);
          end
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int t = 0; t < 4; t++) begin
            logic [31:0] e;
            e = alu_ref((t == 3) ? 4 : ((t == 0) ? 0 : t + 1), vals[i], sext(imms[j]));
            chk(mem[RES2 + (i * 6 + j) * 4 + t] == e, "R5 R3 immediate result",
                mem[RES2 + (i * 6 + j) * 4 + t], e);
          end
      chk(mem[MISC] == 32'd0, "R9 immediate to r0", mem[MISC], 32'd0);
      chk(mem[MISC + 1] == 32'd0, "R9 reg-reg to r0", mem[MISC + 1], 32'd0);
      chk(mem[MISC + 2] == 32'd0, "R8 taken branch skips", mem[MISC + 2], 32'd0);
      chk(mem[MISC + 3] == 32'd11, "R8 taken target", mem[MISC + 3], 32'd11);
      chk(mem[MISC + 4] == 32'd22, "R8 not-taken falls through", mem[MISC + 4], 32'd22);
      chk(mem[MISC + 5] == 32'd15, "R8 backward loop", mem[MISC + 5], 32'd15);
      chk(mem[MISC + 6] == 32'd0, "R2 R10 untouched register", mem[MISC + 6], 32'd0);
      chk(overlap == 0, "R1 read and write together", 32'(overlap), 32'd0);
      chk(badwrite == 0, "R1 R10 stray write", 32'(badwrite), 32'd0);
      chk(measured > 700, "R11 instructions measured", 32'(measured), 32'd700);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule